// File: doc/BRIEF.md
# Paged Address Translator with Page Status Tracking

This block sits between a CPU and its main memory and turns logical addresses in the low 4 MB zone into physical ones. The zone is split into 4 KB pages. A page index picks one 16-bit entry from an on-block page map. The entry's low bits supply the physical page number, and the 12-bit offset is carried across unchanged. Any address at or above the zone limit leaves the block exactly as it came in.

Each entry also carries a two-bit page state and a write-enable bit. When an access is strobed, the translator updates the state in the entry it has just used. A first touch of a page marks it as read or as dirty, and a later write marks it dirty. The new state is stored at the clock edge that ends the access, so the next access already sees it.

Software reaches the map through a byte-wide CPU port. The port carries an 11-bit byte offset, and the even byte of each entry holds its high half. The enclosing address decoder passes only those 11 bits to the port, which is how the rest of the 64 KB register window mirrors the map. Permission checks, fault reporting and the RAM arrays belong to other blocks.

Top module: `pt_translator`

## Requirements
- R1: A logical address at or above 0x400000 comes out on `xl_phys` unchanged, and `xl_present` is high for it.
- R2: For a logical address below 0x400000, `xl_addr[21:12]` selects an entry. `xl_phys[21:12]` is entry bits 9:0, `xl_phys[11:0]` equals `xl_addr[11:0]`, and `xl_phys[23:22]` is zero. The output is combinational in the same cycle.
- R3: Entry bits 14:13 hold the page state: 0 absent, 1 present and untouched, 2 read, 3 dirty. A strobed access to a state-1 page leaves state 2 after a read or state 3 after a write. Bit 15, bits 12:0 and the other entries stay as they were.
- R4: A strobed write to a page in state 2 or 3 leaves state 3. A strobed read leaves the whole entry unchanged.
- R5: For a page in state 0, `xl_present` is low and a strobed access leaves the entry unchanged.
- R6: The status update is stored at the clock edge that ends the access. The CPU port and the next access see it in the following cycle.
- R7: CPU port reads are combinational. `cpu_addr[10:1]` selects the entry. `cpu_addr[0]`=0 returns bits 15:8 and `cpu_addr[0]`=1 returns bits 7:0.
- R8: A CPU write (`cpu_wr_en` high) stores `cpu_wdata` into the addressed byte at the clock edge. The other byte of that entry is left alone.
- R9: If the CPU writes either byte of the entry that a strobed access would update in the same cycle, the status update is dropped and the CPU byte is stored.
- R10: Reset clears every entry to zero, so every page reads back as absent.
- R11: While `xl_valid` is low, no entry changes, whatever the address and `xl_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_valid | input | 1 | Access strobe; enables the status update |
| xl_write | input | 1 | 1 = write access, 0 = read access |
| xl_addr | input | 24 | Logical byte address |
| xl_phys | output | 24 | Physical byte address |
| xl_present | output | 1 | Page present (always 1 outside the zone) |
| cpu_wr_en | input | 1 | CPU byte write to the page map |
| cpu_addr | input | 11 | Byte offset into the map; even = high byte |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte (combinational) |

## Verification
The hardest situation to create is a collision: a CPU write and a strobed access target the same entry in the same cycle, so the status update must give way. The bench drives both sides from one task within a single cycle, first with the CPU writing the high byte and then the low byte. It then reads the entry back to show that the state was not bumped. The second-touch transitions are also hard to reach. To cover them, every page is programmed with a state taken from its own index, then accessed twice in opposite directions, and the state is read back after each access.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int ENT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ST_LSB = 13;
  localparam int WE_BIT = 15;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // Next page state after one strobed access.
  function automatic pg_state_e bump_state(input pg_state_e cur, input logic wr);
    case (cur)
      PG_ABSENT: bump_state = PG_ABSENT;
      PG_FRESH:  bump_state = wr ? PG_DIRTY : PG_READ;
      default:   bump_state = wr ? PG_DIRTY : cur;
    endcase
  endfunction

endpackage

// File: rtl/pt_map_store.sv
module pt_map_store
  import pt_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [ENT_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [ENT_W-1:0] rd_b,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [ENT_W-1:0] upd_val,
  input  logic             byte_we,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic             byte_hi,
  input  logic [BYTE_W-1:0] byte_val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  assign rd_a = mem[rd_idx_a];
  assign rd_b = mem[rd_idx_b];

  // The caller gates upd_en off when both ports target the same entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (upd_en) mem[upd_idx] <= upd_val;
      if (byte_we) begin
        if (byte_hi) mem[byte_idx][ENT_W-1:BYTE_W] <= byte_val;
        else         mem[byte_idx][BYTE_W-1:0]     <= byte_val;
      end
    end
  end
endmodule

// File: rtl/pt_status_upd.sv
module pt_status_upd
  import pt_pkg::*;
(
  input  logic             access,
  input  logic             write,
  input  logic [ENT_W-1:0] entry_in,
  output logic             present,
  output logic             upd_want,
  output logic [ENT_W-1:0] entry_out
);
  pg_state_e cur_st;

  always_comb begin
    cur_st    = pg_state_e'(entry_in[ST_LSB +: 2]);
    present   = (cur_st != PG_ABSENT);
    upd_want  = access && present;
    entry_out = entry_in;
    entry_out[ST_LSB +: 2] = bump_state(cur_st, write);
  end
endmodule

// File: rtl/pt_cpu_port.sv
module pt_cpu_port
  import pt_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W:0]    cpu_addr,
  input  logic [ENT_W-1:0]  entry,
  output logic [IDX_W-1:0]  idx,
  output logic              hi,
  output logic [BYTE_W-1:0] rdata
);
  assign idx   = cpu_addr[IDX_W:1];
  assign hi    = ~cpu_addr[0];
  assign rdata = hi ? entry[ENT_W-1:BYTE_W] : entry[BYTE_W-1:0];
endmodule

// File: rtl/pt_translator.sv
module pt_translator
  import pt_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          PAGE_W   = 10,
  parameter int          OFS_W    = 12,
  parameter int unsigned ZONE_END = 32'h0040_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xl_valid,
  input  logic                xl_write,
  input  logic [ADDR_W-1:0]   xl_addr,
  output logic [ADDR_W-1:0]   xl_phys,
  output logic                xl_present,
  input  logic                cpu_wr_en,
  input  logic [PAGE_W:0]     cpu_addr,
  input  logic [BYTE_W-1:0]   cpu_wdata,
  output logic [BYTE_W-1:0]   cpu_rdata
);
  localparam logic [ADDR_W-1:0] ZONE_LIM = ADDR_W'(ZONE_END);
  localparam int                PHYS_W   = PAGE_W + OFS_W;

  function automatic logic [ADDR_W-1:0] splice(input logic [PAGE_W-1:0] ppn,
                                               input logic [OFS_W-1:0]  ofs);
    splice = ADDR_W'({ppn, ofs});
  endfunction

  logic              in_zone;
  logic [PAGE_W-1:0] xl_idx;
  logic [ENT_W-1:0]  look_entry;
  logic              pg_present;
  logic              upd_want;
  logic              upd_hold;
  logic              upd_en;
  logic [ENT_W-1:0]  upd_entry;
  logic [PAGE_W-1:0] cpu_idx;
  logic              cpu_hi;
  logic [ENT_W-1:0]  cpu_entry;

  assign in_zone = (xl_addr < ZONE_LIM);
  assign xl_idx  = xl_addr[OFS_W +: PAGE_W];

  pt_status_upd u_status (
    .access    (xl_valid && in_zone),
    .write     (xl_write),
    .entry_in  (look_entry),
    .present   (pg_present),
    .upd_want  (upd_want),
    .entry_out (upd_entry)
  );

  pt_cpu_port #(.IDX_W(PAGE_W)) u_cpu (
    .cpu_addr (cpu_addr),
    .entry    (cpu_entry),
    .idx      (cpu_idx),
    .hi       (cpu_hi),
    .rdata    (cpu_rdata)
  );

  // A CPU write to the same entry wins over the status write-back.
  assign upd_hold = cpu_wr_en && (cpu_idx == xl_idx);
  assign upd_en   = upd_want && !upd_hold;

  pt_map_store #(.IDX_W(PAGE_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (xl_idx),
    .rd_a     (look_entry),
    .rd_idx_b (cpu_idx),
    .rd_b     (cpu_entry),
    .upd_en   (upd_en),
    .upd_idx  (xl_idx),
    .upd_val  (upd_entry),
    .byte_we  (cpu_wr_en),
    .byte_idx (cpu_idx),
    .byte_hi  (cpu_hi),
    .byte_val (cpu_wdata)
  );

  generate
    if (PHYS_W <= ADDR_W) begin : g_xlate
      assign xl_phys = in_zone ? splice(look_entry[PAGE_W-1:0], xl_addr[OFS_W-1:0]) : xl_addr;
    end else begin : g_xlate_trunc
      assign xl_phys = xl_addr;
    end
  endgenerate

  assign xl_present = in_zone ? pg_present : 1'b1;
endmodule

// File: rtl/pt_translator_chk.sv
module pt_translator_chk
  import pt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 10,
  parameter int OFS_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xl_valid,
  input logic              xl_write,
  input logic [ADDR_W-1:0] xl_addr,
  input logic [ADDR_W-1:0] xl_phys,
  input logic              xl_present,
  input logic              in_zone,
  input logic [PAGE_W-1:0] xl_idx,
  input logic [ENT_W-1:0]  look_entry,
  input logic              upd_want,
  input logic              upd_hold,
  input logic              cpu_hi,
  input logic [BYTE_W-1:0] cpu_wdata
);
  logic [1:0] st;
  assign st = look_entry[ST_LSB +: 2];

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !in_zone) |-> (xl_phys == xl_addr && xl_present));

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && in_zone) |-> (xl_phys[OFS_W-1:0] == xl_addr[OFS_W-1:0]
                               && xl_phys[OFS_W +: PAGE_W] == look_entry[PAGE_W-1:0]));

  p_fresh_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_want && !upd_hold && st == 2'd1) |=>
      (xl_idx != $past(xl_idx)) || (st == ($past(xl_write) ? 2'd3 : 2'd2)));

  p_other_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_want && !upd_hold) |=>
      (xl_idx != $past(xl_idx)) ||
      ({look_entry[WE_BIT], look_entry[ST_LSB-1:0]} ==
       $past({look_entry[WE_BIT], look_entry[ST_LSB-1:0]})));

  p_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_want && !upd_hold && xl_write && st[1]) |=>
      (xl_idx != $past(xl_idx)) || (st == 2'd3));

  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_want && !upd_hold && !xl_write && st[1]) |=>
      (xl_idx != $past(xl_idx)) || (look_entry == $past(look_entry)));

  p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && in_zone && st == 2'd0) |-> (!xl_present && !upd_want));

  p_cpu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_want && upd_hold) |=>
      (xl_idx != $past(xl_idx)) ||
      ($past(cpu_hi) ? (look_entry[ENT_W-1:BYTE_W] == $past(cpu_wdata))
                     : (look_entry[BYTE_W-1:0] == $past(cpu_wdata)
                        && look_entry[ENT_W-1:BYTE_W] == $past(look_entry[ENT_W-1:BYTE_W]))));
endmodule

bind pt_translator pt_translator_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xl_valid   (xl_valid),
  .xl_write   (xl_write),
  .xl_addr    (xl_addr),
  .xl_phys    (xl_phys),
  .xl_present (xl_present),
  .in_zone    (in_zone),
  .xl_idx     (xl_idx),
  .look_entry (look_entry),
  .upd_want   (upd_want),
  .upd_hold   (upd_hold),
  .cpu_hi     (cpu_hi),
  .cpu_wdata  (cpu_wdata)
);

// File: tb/pt_translator_bench.sv
module pt_translator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES     = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_valid = 1'b0;
  logic        xl_write = 1'b0;
  logic [23:0] xl_addr = '0;
  logic [23:0] xl_phys;
  logic        xl_present;
  logic        cpu_wr_en = 1'b0;
  logic [10:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;

  logic [23:0] got_phys;
  logic        got_present;
  logic [7:0]  got_rdata;

  logic [15:0] model [NPAGES];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_translator u_pt_translator (
    .clk(clk), .rst_n(rst_n),
    .xl_valid(xl_valid), .xl_write(xl_write), .xl_addr(xl_addr),
    .xl_phys(xl_phys), .xl_present(xl_present),
    .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [9:0] ppn_of(input int i);
    ppn_of = 10'((i * 37 + 5) % NPAGES);
  endfunction

  function automatic logic [15:0] ent_of(input int i);
    logic [9:0] ii;
    ii = 10'(i);
    ent_of = {ii[2], ii[1:0], ii[5:3], ppn_of(i)};
  endfunction

  // Page state after one strobed access, from R3/R4/R5.
  function automatic logic [15:0] after_access(input logic [15:0] e, input logic wr);
    logic [15:0] r;
    r = e;
    if (e[14:13] == 2'd1)      r[14:13] = wr ? 2'd3 : 2'd2;
    else if (e[14:13] >= 2'd2) r[14:13] = wr ? 2'd3 : e[14:13];
    after_access = r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus on both sides; outputs sampled before the edge.
  task automatic cycle(input logic v, input logic w, input logic [23:0] a,
                       input logic cw, input logic [10:0] ca, input logic [7:0] cd);
    @(negedge clk);
    xl_valid = v; xl_write = w; xl_addr = a;
    cpu_wr_en = cw; cpu_addr = ca; cpu_wdata = cd;
    #2;
    got_phys = xl_phys; got_present = xl_present; got_rdata = cpu_rdata;
    @(posedge clk);
    #1;
    xl_valid = 1'b0; cpu_wr_en = 1'b0;
  endtask

  task automatic cpu_wr(input logic [10:0] ca, input logic [7:0] d);
    cycle(1'b0, 1'b0, 24'h0, 1'b1, ca, d);
  endtask

  task automatic cpu_rd(input logic [10:0] ca);
    cycle(1'b0, 1'b0, 24'h0, 1'b0, ca, 8'h00);
  endtask

  task automatic set_entry(input int p, input logic [15:0] e);
    cpu_wr(11'(2 * p), e[15:8]);
    cpu_wr(11'(2 * p + 1), e[7:0]);
    model[p] = e;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: every byte reads zero after reset; a page reads absent.
    for (int i = 0; i < 2 * NPAGES; i++) begin
      cpu_rd(11'(i));
      check("R10 reset byte", 32'(got_rdata), 32'h0);
    end
    cycle(1'b1, 1'b0, 24'h005123, 1'b0, 11'h0, 8'h0);
    check("R10 absent after reset", 32'(got_present), 32'h0);
    check("R2 phys with zero entry", 32'(got_phys), 32'h000123);

    // R8: program every entry byte by byte.
    for (int i = 0; i < NPAGES; i++) set_entry(i, ent_of(i));

    // R7/R8: read both bytes back.
    for (int i = 0; i < NPAGES; i++) begin
      cpu_rd(11'(2 * i));
      check("R7 high byte at even offset", 32'(got_rdata), 32'(model[i][15:8]));
      cpu_rd(11'(2 * i + 1));
      check("R7 low byte at odd offset", 32'(got_rdata), 32'(model[i][7:0]));
    end

    // R2/R3/R4/R5/R6: two opposite accesses per page, state read back after each.
    for (int i = 0; i < NPAGES; i++) begin
      logic [9:0]  ii;
      logic [11:0] ofs;
      logic        w1;
      logic [23:0] a;
      ii  = 10'(i);
      ofs = 12'((i * 91) % 4096);
      w1  = ii[3];
      a   = {2'b00, ii, ofs};
      for (int k = 0; k < 2; k++) begin
        logic wr;
        wr = (k == 0) ? w1 : ~w1;
        cycle(1'b1, wr, a, 1'b0, 11'h0, 8'h0);
        check("R2 translated address", 32'(got_phys), 32'({2'b00, model[i][9:0], ofs}));
        check("R5 present flag", 32'(got_present), 32'(model[i][14:13] != 2'd0));
        model[i] = after_access(model[i], wr);
        cpu_rd(11'(2 * i));
        check("R6 R3 R4 state after access", 32'(got_rdata), 32'(model[i][15:8]));
      end
      cpu_rd(11'(2 * i + 1));
      check("R3 low byte preserved", 32'(got_rdata), 32'(model[i][7:0]));
    end

    // R1: pass-through above the zone; map untouched.
    begin
      logic [23:0] pa [4];
      pa[0] = 24'h400000; pa[1] = 24'h7FFFFF; pa[2] = 24'hABCDEF; pa[3] = 24'hFFFFFF;
      for (int j = 0; j < 4; j++) begin
        cycle(1'b1, j[0], pa[j], 1'b0, 11'h0, 8'h0);
        check("R1 pass-through address", 32'(got_phys), 32'(pa[j]));
        check("R1 present outside zone", 32'(got_present), 32'h1);
      end
      cpu_rd(11'h000);
      check("R1 map untouched", 32'(got_rdata), 32'(model[0][15:8]));
    end

    // R11: no strobe, no update.
    set_entry(77, 16'h2345);
    cycle(1'b0, 1'b1, 24'h04D010, 1'b0, 11'h0, 8'h0);
    cpu_rd(11'(2 * 77));
    check("R11 no update without strobe", 32'(got_rdata), 32'h23);

    // R9: CPU writes high byte of the entry being accessed.
    set_entry(200, 16'hA012);
    cycle(1'b1, 1'b1, {2'b00, 10'd200, 12'h444}, 1'b1, 11'(2 * 200), 8'hB1);
    cpu_rd(11'(2 * 200));
    check("R9 CPU high byte wins", 32'(got_rdata), 32'hB1);
    // R9: CPU writes low byte; state must not be bumped.
    set_entry(201, 16'h2034);
    cycle(1'b1, 1'b1, {2'b00, 10'd201, 12'h010}, 1'b1, 11'(2 * 201 + 1), 8'h5C);
    cpu_rd(11'(2 * 201));
    check("R9 state not bumped", 32'(got_rdata), 32'h20);
    cpu_rd(11'(2 * 201 + 1));
    check("R9 CPU low byte stored", 32'(got_rdata), 32'h5C);
    // R9 negative: different entries, both updates land.
    set_entry(300, 16'h2001);
    set_entry(301, 16'h0000);
    cycle(1'b1, 1'b0, {2'b00, 10'd300, 12'h0}, 1'b1, 11'(2 * 301), 8'h77);
    cpu_rd(11'(2 * 300));
    check("R9 other entry still updated", 32'(got_rdata), 32'h40);
    cpu_rd(11'(2 * 301));
    check("R8 concurrent CPU write", 32'(got_rdata), 32'h77);

    // R6: back-to-back accesses; the second sees the first's update via present.
    set_entry(400, 16'h2000);
    cycle(1'b1, 1'b0, {2'b00, 10'd400, 12'h0}, 1'b0, 11'h0, 8'h0);
    cycle(1'b1, 1'b1, {2'b00, 10'd400, 12'h0}, 1'b0, 11'h0, 8'h0);
    cpu_rd(11'(2 * 400));
    check("R6 chained updates", 32'(got_rdata), 32'h60);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule